// File: doc/BRIEF.md
# Floppy Controller Host Command Handshake

This block is the register face that a floppy disk controller shows to its host processor. The host reaches two registers through chip select, read and write strobes and a single address bit: a main status register that can be polled at any time, and an 8-bit data register that carries command bytes in and result bytes out. Each command passes through a command phase, an execution phase and a result phase. The first command byte selects an opcode, and the opcode sets how many bytes belong to each phase.

The status register tells the host when it may touch the data register and in which direction. After every accepted data byte, the ready flag stays low for a recovery window, which is a count of system clock cycles. The execution phase is a stub whose length comes from an input port. An interrupt marks its end.

Head-positioning commands (seek, recalibrate) have no result phase. Their interrupt stays pending until the host issues a sense-interrupt command, which returns the drive unit and the cylinder. The bench replaces the execution stub's length and the result contents with fixed, computable values so the handshake can be checked on its own.

Top module: `fdc_host_if`

## Requirements
- R1: With chip select low, address bit low selects the status register and address bit high selects the data register. Reading the status register, or writing with the address bit low, never changes the command sequence.
- R2: Status bit 7 is ready-for-host. Status bit 6 is direction: 0 means the host writes, 1 means the host reads. Direction is 1 only in the result phase. Ready is 0 throughout execution.
- R3: After every accepted data-register byte, in either direction, status bit 7 reads 0 for exactly RECOV_CYCLES clock cycles.
- R4: A data-register write is ignored while ready is 0 or while direction is 1. A data-register read in those conditions does not advance the result sequence.
- R5: The low five bits of the first byte pick the byte counts (command/result). Read data 0x06 is 9/7, write data 0x05 is 9/7, seek 0x0F is 3/0, recalibrate 0x07 is 2/0, sense drive status 0x04 is 2/1, sense interrupt 0x08 is 1/2. Any other code is 1 command byte and returns the single result byte 0x80.
- R6: Execution starts right after the last command byte. It lasts max(exec_len,1) cycles, and irq rises at its end. Read, write, seek and recalibrate have an execution phase. During that phase, status bit 5 mirrors the nondma input sampled at the last command byte.
- R7: For opcodes 0x06, 0x05 and 0x04, result byte k equals command byte k XOR RES_MASK.
- R8: Reading the first result byte clears irq.
- R9: After seek or recalibrate, the block returns to idle with irq still high. The next sense-interrupt command clears irq when it is accepted and returns two bytes: 0x20 OR the unit (bits 1:0 of command byte 1), then the cylinder. The cylinder is byte 2 of a seek, or 0 for recalibrate.
- R10: A sense-interrupt command with no pending head-positioning interrupt returns the single byte 0x80.
- R11: Status bit 4 (busy) is 1 from the first accepted command byte until the last result byte is read, or until execution ends for commands without results. Bits 3:0 read 0.
- R12: After reset, status reads 0x80 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register select: 1 data, 0 status |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host (status or result byte) |
| nondma | input | 1 | Non-DMA mode for the command being issued |
| exec_len | input | EXEC_W | Execution stub length in cycles |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RECOV_CYCLES set to 8 rather than the 12-microsecond default. This keeps the recovery window short enough to count cycle by cycle, and lets a full nine-byte command run many times within the run. The bench drives exec_len at run time to 3 for table commands and 5 for the exact-length test. That makes the first and last execution cycles, the interrupt edge and the non-DMA flag observable. RES_MASK stays at 0xC0, so every result byte is predictable from the command bytes the bench sent.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;

   localparam int CMD_MAX = 9;
   localparam int CNT_W   = $clog2(CMD_MAX + 1);
   localparam int RES_W   = 3;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CMD    = 2'd1,
      PH_EXEC   = 2'd2,
      PH_RESULT = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      RK_ECHO  = 2'd0,
      RK_SENSE = 2'd1,
      RK_BAD   = 2'd2
   } res_kind_t;

   typedef struct packed {
      logic [CNT_W-1:0] ncmd;
      logic [RES_W-1:0] nres;
      logic             has_exec;
      res_kind_t        kind;
   } op_info_t;

   localparam logic [4:0] OP_READ   = 5'h06;
   localparam logic [4:0] OP_WRITE  = 5'h05;
   localparam logic [4:0] OP_SEEK   = 5'h0F;
   localparam logic [4:0] OP_RECAL  = 5'h07;
   localparam logic [4:0] OP_DSTAT  = 5'h04;
   localparam logic [4:0] OP_SENSEI = 5'h08;

   localparam logic [7:0] BAD_CODE  = 8'h80;
   localparam logic [5:0] SENSE_HI  = 6'b001000;

   function automatic op_info_t op_lookup(input logic [4:0] op);
      op_info_t r;
      case (op)
         OP_READ, OP_WRITE: r = '{ncmd: 4'd9, nres: 3'd7, has_exec: 1'b1, kind: RK_ECHO};
         OP_SEEK:           r = '{ncmd: 4'd3, nres: 3'd0, has_exec: 1'b1, kind: RK_ECHO};
         OP_RECAL:          r = '{ncmd: 4'd2, nres: 3'd0, has_exec: 1'b1, kind: RK_ECHO};
         OP_DSTAT:          r = '{ncmd: 4'd2, nres: 3'd1, has_exec: 1'b0, kind: RK_ECHO};
         OP_SENSEI:         r = '{ncmd: 4'd1, nres: 3'd2, has_exec: 1'b0, kind: RK_SENSE};
         default:           r = '{ncmd: 4'd1, nres: 3'd1, has_exec: 1'b0, kind: RK_BAD};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/fdc_strobe_edge.sv
module fdc_strobe_edge #(
   parameter int N_STB = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sel,
   input  logic [N_STB-1:0] stb_n,
   output logic [N_STB-1:0] ev
);
   for (genvar g = 0; g < N_STB; g++) begin : g_stb
      logic idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) idle_q <= 1'b1;
         else        idle_q <= stb_n[g] | cs_n;
      end
      assign ev[g] = idle_q & ~stb_n[g] & ~cs_n & sel;
   end
endmodule

// File: rtl/fdc_recovery_timer.sv
module fdc_recovery_timer #(
   parameter int CYC = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic idle
);
   if (CYC < 0) begin : g_bad_cyc
      $error("fdc_recovery_timer: CYC must not be negative");
   end

   if (CYC == 0) begin : g_none
      assign idle = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(CYC + 1);
      localparam logic [CW-1:0] LOAD = CW'(CYC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (start)       cnt <= LOAD;
         else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
      assign idle = (cnt == '0);
   end
endmodule

// File: rtl/fdc_phase_ctrl.sv
module fdc_phase_ctrl
   import fdc_hs_pkg::*;
#(
   parameter int         EXEC_W   = 16,
   parameter logic [7:0] RES_MASK = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic              rd_ev,
   input  logic [7:0]        din,
   input  logic              nondma,
   input  logic [EXEC_W-1:0] exec_len,
   input  logic              rec_idle,
   output logic              rqm,
   output logic              dio,
   output logic              busy,
   output logic              ndm,
   output logic              irq,
   output logic [7:0]        res_byte,
   output logic              byte_done,
   output logic              res_read
);
   phase_t           phase;
   op_info_t         info_r;
   op_info_t         info_in;
   op_info_t         fin_info;
   logic [CNT_W-1:0] cnt;
   logic [RES_W-1:0] ridx;
   logic [EXEC_W-1:0] ecnt;
   logic [7:0]       cbuf [CMD_MAX];
   logic             ndm_r;
   logic             pend;
   logic [1:0]       p_unit;
   logic [7:0]       p_cyl;
   logic             wr_take, last_cmd;

   assign rqm       = rec_idle & (phase != PH_EXEC);
   assign dio       = (phase == PH_RESULT);
   assign busy      = (phase != PH_IDLE);
   assign ndm       = (phase == PH_EXEC) & ndm_r;
   assign wr_take   = wr_ev & rqm & ~dio;
   assign res_read  = rd_ev & rqm & dio;
   assign byte_done = wr_take | res_read;

   assign info_in  = op_lookup(din[4:0]);
   assign fin_info = (phase == PH_IDLE) ? info_in : info_r;
   assign last_cmd = wr_take &
                     (((phase == PH_IDLE) && (info_in.ncmd == CNT_W'(1))) ||
                      ((phase == PH_CMD) && ((cnt + 1'b1) == info_r.ncmd)));

   always_comb begin
      case (info_r.kind)
         RK_ECHO:  res_byte = cbuf[ridx] ^ RES_MASK;
         RK_SENSE: res_byte = (ridx == '0) ? {SENSE_HI, p_unit} : p_cyl;
         default:  res_byte = BAD_CODE;
      endcase
      if (phase != PH_RESULT) res_byte = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CMD_MAX; i++) cbuf[i] <= 8'h00;
      end else if (wr_take) begin
         if (phase == PH_IDLE)     cbuf[0]   <= din;
         else if (phase == PH_CMD) cbuf[cnt] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         info_r <= '{ncmd: '0, nres: '0, has_exec: 1'b0, kind: RK_ECHO};
         cnt    <= '0;
         ridx   <= '0;
         ecnt   <= '0;
         ndm_r  <= 1'b0;
         pend   <= 1'b0;
         p_unit <= 2'd0;
         p_cyl  <= 8'h00;
         irq    <= 1'b0;
      end else begin
         if (wr_take && phase == PH_IDLE) begin
            info_r <= info_in;
            phase  <= PH_CMD;
            cnt    <= CNT_W'(1);
         end else if (wr_take && phase == PH_CMD) begin
            cnt <= cnt + 1'b1;
         end

         if (last_cmd) begin
            ridx <= '0;
            if (fin_info.has_exec) begin
               phase <= PH_EXEC;
               ecnt  <= (exec_len == '0) ? EXEC_W'(1) : exec_len;
               ndm_r <= nondma;
            end else begin
               phase <= PH_RESULT;
               if (fin_info.kind == RK_SENSE) begin
                  if (pend) begin
                     info_r.kind <= RK_SENSE;
                     info_r.nres <= RES_W'(2);
                     pend        <= 1'b0;
                     irq         <= 1'b0;
                  end else begin
                     info_r.kind <= RK_BAD;
                     info_r.nres <= RES_W'(1);
                  end
               end
            end
         end

         if (phase == PH_EXEC) begin
            if (ecnt <= EXEC_W'(1)) begin
               irq <= 1'b1;
               if (info_r.nres == '0) begin
                  phase  <= PH_IDLE;
                  pend   <= 1'b1;
                  p_unit <= cbuf[1][1:0];
                  p_cyl  <= (info_r.ncmd == CNT_W'(3)) ? cbuf[2] : 8'h00;
               end else begin
                  phase <= PH_RESULT;
               end
            end else begin
               ecnt <= ecnt - 1'b1;
            end
         end

         if (res_read) begin
            irq <= 1'b0;
            if ((ridx + 1'b1) == info_r.nres) phase <= PH_IDLE;
            else                              ridx  <= ridx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fdc_host_if.sv
module fdc_host_if
   import fdc_hs_pkg::*;
#(
   parameter int         RECOV_CYCLES = 3000,
   parameter int         EXEC_W       = 16,
   parameter logic [7:0] RES_MASK     = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   input  logic              nondma,
   input  logic [EXEC_W-1:0] exec_len,
   output logic              irq
);
   if (EXEC_W < 1 || EXEC_W > 32) begin : g_bad_ew
      $error("fdc_host_if: EXEC_W out of range");
   end

   logic [1:0] ev;
   logic       wr_ev, rd_ev;
   logic       rec_idle, rqm, dio, busy, ndm;
   logic       byte_done, res_read;
   logic [7:0] res_byte;
   logic [7:0] status_w;

   fdc_strobe_edge #(.N_STB(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .sel   (a0),
      .stb_n ({rd_n, wr_n}),
      .ev    (ev)
   );
   assign wr_ev = ev[0];
   assign rd_ev = ev[1];

   fdc_recovery_timer #(.CYC(RECOV_CYCLES)) u_rec (
      .clk   (clk),
      .rst_n (rst_n),
      .start (byte_done),
      .idle  (rec_idle)
   );

   fdc_phase_ctrl #(.EXEC_W(EXEC_W), .RES_MASK(RES_MASK)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ev     (wr_ev),
      .rd_ev     (rd_ev),
      .din       (din),
      .nondma    (nondma),
      .exec_len  (exec_len),
      .rec_idle  (rec_idle),
      .rqm       (rqm),
      .dio       (dio),
      .busy      (busy),
      .ndm       (ndm),
      .irq       (irq),
      .res_byte  (res_byte),
      .byte_done (byte_done),
      .res_read  (res_read)
   );

   assign status_w = {rqm, dio, ndm, busy, 4'b0000};
   assign dout     = a0 ? res_byte : status_w;
endmodule

// File: rtl/fdc_host_if_chk.sv
module fdc_host_if_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status_w,
   input logic       irq,
   input logic       byte_done,
   input logic       res_read
);
   // R2: read direction only while a command is in progress
   a_r2_dio_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      status_w[6] |-> status_w[4]);

   // R3: an accepted byte always pulls ready low on the next cycle
   a_r3_rqm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !status_w[7]);

   // R6: non-DMA flag only inside execution (busy, not ready, host-write direction)
   a_r6_ndm_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
      status_w[5] |-> (status_w[4] && !status_w[7] && !status_w[6]));

   // R8: reading a result byte clears the interrupt
   a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      res_read |=> !irq);

   // R11: busy only starts with an accepted command byte
   a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_w[4]) |-> $past(byte_done));

   // R11: low nibble always zero
   a_r11_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_w[3:0] == 4'b0000);
endmodule

bind fdc_host_if fdc_host_if_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .status_w  (status_w),
   .irq       (irq),
   .byte_done (byte_done),
   .res_read  (res_read)
);

// File: tb/tb_fdc_host_if.sv
module tb_fdc_host_if;
   localparam int REC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
   logic [7:0]  din = 8'h00;
   logic [7:0]  dout;
   logic        nondma = 1'b0;
   logic [15:0] exec_len = 16'd3;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fdc_host_if #(.RECOV_CYCLES(REC), .EXEC_W(16), .RES_MASK(8'hC0)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
      .din(din), .dout(dout), .nondma(nondma), .exec_len(exec_len), .irq(irq));

   // byte0[19:12] ncmd[11:8] nres[7:4] exec[1] bad[0]
   localparam logic [19:0] VEC [5] = '{
      {8'h46, 4'd9, 4'd7, 2'b00, 1'b1, 1'b0},
      {8'hC5, 4'd9, 4'd7, 2'b00, 1'b1, 1'b0},
      {8'h04, 4'd2, 4'd1, 2'b00, 1'b0, 1'b0},
      {8'h1F, 4'd1, 4'd1, 2'b00, 1'b0, 1'b1},
      {8'h00, 4'd1, 4'd1, 2'b00, 1'b0, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic st_now(output logic [7:0] s);
      a0 = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
      #1 s = dout;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic st_read(output logic [7:0] s);
      @(negedge clk);
      st_now(s);
   endtask

   task automatic wait_ready(input bit dir);
      logic [7:0] s;
      int n = 0;
      st_read(s);
      while (!(s[7] && s[6] == dir) && n < 400) begin
         st_read(s);
         n++;
      end
      if (n >= 400) chk(1'b0, "R2 ready timeout", s, {1'b1, dir, 6'h0});
   endtask

   task automatic raw_wr(input logic [7:0] b, input logic sel);
      @(negedge clk);
      a0 = sel; din = b; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic wr_byte(input logic [7:0] b);
      wait_ready(1'b0);
      raw_wr(b, 1'b1);
   endtask

   task automatic rd_byte(output logic [7:0] b);
      wait_ready(1'b1);
      @(negedge clk);
      a0 = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
      #1 b = dout;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic wait_irq();
      int n = 0;
      while (!irq && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, b;
      logic [7:0] bytes [9];
      int cnt;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      st_read(s);
      chk(s == 8'h80, "R12 status after reset", s, 8'h80);
      chk(irq == 1'b0, "R12 irq after reset", irq, 0);

      // Table-driven commands: R5, R7, R6, R10
      for (int v = 0; v < 5; v++) begin
         logic [19:0] e;
         int nc, nr;
         e  = VEC[v];
         nc = int'(e[11:8]);
         nr = int'(e[7:4]);
         bytes[0] = e[19:12];
         for (int k = 1; k < 9; k++) bytes[k] = 8'h30 + 8'(k) + 8'(v << 4);
         for (int k = 0; k < nc; k++) begin
            if (k == nc - 1 && nc > 1) begin
               st_read(s);
               chk(s[4] && !s[6], "R5 still in command phase", s, 8'h10);
            end
            wr_byte(bytes[k]);
         end
         if (e[1]) begin
            wait_irq();
            chk(irq == 1'b1, "R6 irq at end of execution", irq, 1);
         end
         for (int k = 0; k < nr; k++) begin
            rd_byte(b);
            if (e[0]) chk(b == 8'h80, "R5 unknown opcode result", b, 8'h80);
            else      chk(b == (bytes[k] ^ 8'hC0), "R7 echoed result byte", b, bytes[k] ^ 8'hC0);
         end
         wait_ready(1'b0);
         st_read(s);
         chk(s == 8'h80, "R11 idle after last result", s, 8'h80);
      end

      // R3 exact recovery window
      wr_byte(8'h04);
      st_now(s);
      cnt = 0;
      while (!s[7] && cnt < 50) begin
         cnt++;
         @(negedge clk);
         st_now(s);
      end
      chk(cnt == REC, "R3 recovery cycles", cnt, REC);
      wr_byte(8'h01);
      rd_byte(b);
      chk(b == (8'h04 ^ 8'hC0), "R7 drive status byte", b, 8'hC4);

      // R1/R4: ignored writes and status reads mid-command
      wr_byte(8'h46);
      raw_wr(8'h99, 1'b1);           // during recovery: ignored (R4)
      wait_ready(1'b0);
      raw_wr(8'h77, 1'b0);           // status-address write: ignored (R1)
      for (int k = 1; k < 8; k++) wr_byte(8'h50 + 8'(k));
      wait_ready(1'b0);
      st_read(s);
      st_read(s);
      chk(s == 8'h90, "R4 ignored writes not counted", s, 8'h90);
      chk(s[4] == 1'b1, "R1 status reads leave sequence", s[4], 1);
      wr_byte(8'h58);
      wait_irq();
      chk(irq == 1'b1, "R6 irq after read execution", irq, 1);
      raw_wr(8'h11, 1'b1);           // write in result phase: ignored (R4)
      rd_byte(b);
      chk(b == (8'h46 ^ 8'hC0), "R7 result 0", b, 8'h86);
      chk(irq == 1'b0, "R8 irq cleared by first result read", irq, 0);
      rd_byte(b);
      chk(b == (8'h51 ^ 8'hC0), "R4 result 1 from real byte", b, 8'h91);
      for (int k = 2; k < 7; k++) rd_byte(b);
      chk(b == (8'h56 ^ 8'hC0), "R7 last result", b, 8'h96);

      // R6 exact execution length with non-DMA, R9 seek
      exec_len = 16'd5;
      nondma = 1'b1;
      wr_byte(8'h0F);
      wr_byte(8'h01);
      wr_byte(8'h2A);
      nondma = 1'b0;
      st_now(s);
      cnt = 0;
      while (s[5] && cnt < 50) begin
         cnt++;
         @(negedge clk);
         st_now(s);
      end
      chk(cnt == 5, "R6 execution cycles with non-DMA flag", cnt, 5);
      chk(irq == 1'b1, "R9 irq after seek", irq, 1);
      chk(s[4] == 1'b0, "R9 seek returns idle", s, 0);
      exec_len = 16'd3;
      wr_byte(8'h08);
      chk(irq == 1'b0, "R9 sense clears irq", irq, 0);
      rd_byte(b);
      chk(b == 8'h21, "R9 sense unit byte", b, 8'h21);
      rd_byte(b);
      chk(b == 8'h2A, "R9 sense cylinder", b, 8'h2A);

      // R10 sense with nothing pending
      wr_byte(8'h08);
      rd_byte(b);
      chk(b == 8'h80, "R10 sense without pending", b, 8'h80);
      wait_ready(1'b0);
      st_read(s);
      chk(s == 8'h80, "R10 single byte then idle", s, 8'h80);

      // R9 recalibrate, R6 zero length treated as one
      exec_len = 16'd0;
      wr_byte(8'h07);
      wr_byte(8'h02);
      st_now(s);
      chk(s[4] == 1'b1 && s[7] == 1'b0, "R6 zero length still executes", s, 8'h10);
      @(negedge clk);
      chk(irq == 1'b1, "R6 zero length ends in one cycle", irq, 1);
      wr_byte(8'h08);
      rd_byte(b);
      chk(b == 8'h22, "R9 recal unit byte", b, 8'h22);
      rd_byte(b);
      chk(b == 8'h00, "R9 recal cylinder", b, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule